// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block picks, out of a vector of eligible interrupt lines, the single line that should be served next. It also decides whether that line may interrupt the exception level that is running now. Every line carries an 8-bit priority value, and a numerically lower value is more urgent. Only the top `PRIO_BITS` bits of each value are built. The bits below them are cleared on entry, so any value written to them has no effect.

A 3-bit group selector splits each priority into two parts. The upper part is the preempt field and the lower part is the subpriority. Only the preempt field decides whether the current level is interrupted. Subpriority, and after it the line number, decide only which eligible line is chosen.

The search is a binary compare tree with one register stage per level. Inputs are captured on one edge and the answer appears `$clog2(NUM_LINES)+1` edges later. A new set of inputs may be presented on every cycle.

Top module: `gpa_arbiter`

## Requirements
- R1: Among eligible lines, the winner is the line with the smallest masked priority value, and `win_prio` reports that masked value.
- R2: Priority bits below the top `PRIO_BITS` are treated as zero: they never influence selection, and `win_prio` always shows them as zero (for `PRIO_BITS`=3 the mask is 0xE0).
- R3: When two or more eligible lines have equal masked priority, the lowest line number wins.
- R4: With group value G from 0 to 6, the preempt field is bits [7:G+1]. `preempt_req` is 1 only when the winner's preempt field is strictly smaller than the running level's preempt field. A difference only in bits [G:0] never raises it.
- R5: With G = 7 there is no preempt field. While a programmable level runs (`run_level[8]`=0), `preempt_req` stays 0, but a winner is still reported.
- R6: While `run_fixed` is 1, meaning a fixed-priority exception above all programmable levels is running, `preempt_req` is 0.
- R7: When `run_level[8]` is 1 (no exception running) and `run_fixed` is 0, any eligible line raises `preempt_req`.
- R8: With no eligible line, `win_vld` and `preempt_req` are 0. All outputs are 0 after reset.
- R9: Outputs reflect the inputs sampled `$clog2(NUM_LINES)+1` rising edges earlier. Inputs changing on every cycle produce a matching result on every cycle, in order.
- R10: The running level's own unimplemented bits and subpriority bits are ignored: `run_level[7:0]` is masked with the implemented mask and the preempt mask before the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| eligible | input | NUM_LINES | One bit per line that may be served |
| prio_flat | input | NUM_LINES*8 | Priority of line i in bits [8i+7:8i] |
| group_sel | input | 3 | Group value G splitting preempt and subpriority |
| run_level | input | 9 | Bit 8: nothing running; bits 7:0: priority of the running handler |
| run_fixed | input | 1 | A fixed-priority exception is running |
| win_vld | output | 1 | A winner exists |
| win_line | output | $clog2(NUM_LINES) | Winning line number |
| win_prio | output | 8 | Masked priority of the winner |
| preempt_req | output | 1 | The winner may preempt the running level |

## Verification
Each tie-breaking layer is isolated by its own pattern. Distinct priorities test plain ordering. Values that differ only in unbuilt bits show that masking happens before comparison. Fully equal priorities spread over scattered lines expose the line-number rule.

Preemption is tried by sweeping the group value against one fixed pair of request and running priorities. This separates a compare on the preempt field from a compare on the full value. Further cases cover the idle code, the fixed-level flag and G = 7.

A long stream of random vectors, with new inputs on every cycle, checks that results follow the inputs in order after the stated latency.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
    localparam int PRIO_W = 8;
    localparam int LINE_W = 8;

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] prio;
        logic [LINE_W-1:0] line;
    } node_t;
endpackage

// File: rtl/gpa_prio_mask.sv
module gpa_prio_mask
    import gpa_pkg::*;
#(
    parameter int PRIO_BITS = 3,
    parameter int LINE_IDX  = 0
) (
    input  logic [PRIO_W-1:0] prio_raw,
    input  logic              elig,
    output node_t             leaf
);
    localparam logic [PRIO_W-1:0] IMPL_MASK = PRIO_W'(8'hFF << (PRIO_W - PRIO_BITS));

    always_comb begin
        leaf.vld  = elig;
        leaf.prio = prio_raw & IMPL_MASK;
        leaf.line = LINE_W'(LINE_IDX);
    end
endmodule

// File: rtl/gpa_cmp_node.sv
module gpa_cmp_node
    import gpa_pkg::*;
(
    input  node_t lo,
    input  node_t hi,
    output node_t win
);
    // lower-numbered subtree is kept on equal priority
    logic take_hi;

    always_comb begin
        take_hi = hi.vld && (!lo.vld || (hi.prio < lo.prio));
        win     = take_hi ? hi : lo;
    end
endmodule

// File: rtl/gpa_preempt_chk.sv
module gpa_preempt_chk
    import gpa_pkg::*;
#(
    parameter int PRIO_BITS = 3
) (
    input  node_t       root,
    input  logic [2:0]  grp,
    input  logic [8:0]  run,
    input  logic        fixed,
    output logic        preempt
);
    localparam logic [PRIO_W-1:0] IMPL_MASK = PRIO_W'(8'hFF << (PRIO_W - PRIO_BITS));

    logic [8:0]        shifted;
    logic [PRIO_W-1:0] pre_mask;
    logic [PRIO_W-1:0] req_pre;
    logic [PRIO_W-1:0] run_pre;

    always_comb begin
        shifted  = 9'h0FF << (4'(grp) + 4'd1);
        pre_mask = shifted[PRIO_W-1:0];
        req_pre  = root.prio & pre_mask;
        run_pre  = run[PRIO_W-1:0] & IMPL_MASK & pre_mask;
        preempt  = root.vld && !fixed && (run[8] || (req_pre < run_pre));
    end
endmodule

// File: rtl/gpa_arbiter.sv
module gpa_arbiter
    import gpa_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int PRIO_BITS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LINES-1:0]         eligible,
    input  logic [NUM_LINES*PRIO_W-1:0]  prio_flat,
    input  logic [2:0]                   group_sel,
    input  logic [8:0]                   run_level,
    input  logic                         run_fixed,
    output logic                         win_vld,
    output logic [$clog2(NUM_LINES)-1:0] win_line,
    output logic [PRIO_W-1:0]            win_prio,
    output logic                         preempt_req
);
    localparam int LVLS  = $clog2(NUM_LINES);
    localparam int PAD   = 1 << LVLS;
    localparam int NODES = 2 * PAD;

    typedef struct packed {
        node_t [NODES-1:0]   tree;
        logic  [LVLS:0][2:0] grp;
        logic  [LVLS:0][8:0] run;
        logic  [LVLS:0]      fixed;
    } state_t;

    state_t st_d, st_q;
    node_t  comb_w [NODES];

    // tree nodes: 1 is the root, PAD..NODES-1 are the leaves
    for (genvar i = 0; i < NODES; i++) begin : g_node
        if (i == 0) begin : g_unused
            assign comb_w[i] = '0;
        end else if (i < PAD) begin : g_cmp
            gpa_cmp_node u_cmp (
                .lo  (st_q.tree[2*i]),
                .hi  (st_q.tree[2*i+1]),
                .win (comb_w[i])
            );
        end else if (i - PAD < NUM_LINES) begin : g_leaf
            gpa_prio_mask #(
                .PRIO_BITS (PRIO_BITS),
                .LINE_IDX  (i - PAD)
            ) u_mask (
                .prio_raw (prio_flat[(i-PAD)*PRIO_W +: PRIO_W]),
                .elig     (eligible[i-PAD]),
                .leaf     (comb_w[i])
            );
        end else begin : g_pad
            assign comb_w[i] = '0;
        end
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NODES; k++) begin
            st_d.tree[k] = comb_w[k];
        end
        st_d.grp[0]   = group_sel;
        st_d.run[0]   = run_level;
        st_d.fixed[0] = run_fixed;
        for (int k = 1; k <= LVLS; k++) begin
            st_d.grp[k]   = st_q.grp[k-1];
            st_d.run[k]   = st_q.run[k-1];
            st_d.fixed[k] = st_q.fixed[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    node_t      root;
    logic [2:0] grp_last;
    logic [8:0] run_last;
    logic       fixed_last;

    assign root       = st_q.tree[1];
    assign grp_last   = st_q.grp[LVLS];
    assign run_last   = st_q.run[LVLS];
    assign fixed_last = st_q.fixed[LVLS];

    gpa_preempt_chk #(.PRIO_BITS(PRIO_BITS)) u_pre (
        .root    (root),
        .grp     (grp_last),
        .run     (run_last),
        .fixed   (fixed_last),
        .preempt (preempt_req)
    );

    assign win_vld  = root.vld;
    assign win_line = root.line[LVLS-1:0];
    assign win_prio = root.prio;
endmodule

// File: rtl/gpa_arbiter_chk.sv
module gpa_arbiter_chk #(
    parameter int NUM_LINES = 8,
    parameter int PRIO_BITS = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         win_vld,
    input logic [$clog2(NUM_LINES)-1:0] win_line,
    input logic [7:0]                   win_prio,
    input logic                         preempt_req,
    input logic [2:0]                   grp_last,
    input logic [8:0]                   run_last,
    input logic                         fixed_last
);
    localparam logic [7:0] IMPL_MASK = 8'(8'hFF << (8 - PRIO_BITS));

    // R8
    no_pre_without_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_req |-> win_vld);

    // R2
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_prio & ~IMPL_MASK) == 8'h00);

    // R1
    line_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (32'(win_line) < NUM_LINES));

    // R5
    group7_no_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_last == 3'd7 && !run_last[8]) |-> !preempt_req);

    // R6
    fixed_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_last |-> !preempt_req);

    // R7
    idle_takes_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_last[8] && !fixed_last && win_vld) |-> preempt_req);
endmodule

bind gpa_arbiter gpa_arbiter_chk #(
    .NUM_LINES (NUM_LINES),
    .PRIO_BITS (PRIO_BITS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_vld     (win_vld),
    .win_line    (win_line),
    .win_prio    (win_prio),
    .preempt_req (preempt_req),
    .grp_last    (grp_last),
    .run_last    (run_last),
    .fixed_last  (fixed_last)
);

// File: tb/gpa_arbiter_tb.sv
module gpa_arbiter_tb_top;
    localparam int N   = 8;
    localparam int PB  = 3;
    localparam int LW  = $clog2(N);
    localparam int LAT = LW + 1;
    localparam logic [7:0] IMPL = 8'(8'hFF << (8 - PB));

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    eligible = '0;
    logic [N*8-1:0]  prio_flat = '0;
    logic [2:0]      group_sel = '0;
    logic [8:0]      run_level = '0;
    logic            run_fixed = 1'b0;
    logic            win_vld;
    logic [LW-1:0]   win_line;
    logic [7:0]      win_prio;
    logic            preempt_req;

    always #10 clk = ~clk;

    gpa_arbiter #(.NUM_LINES(N), .PRIO_BITS(PB)) dut_i (.*);

    typedef struct {
        int          due;
        logic        vld;
        int          line;
        logic [7:0]  prio;
        logic        pre;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [7:0]  pr [N];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic exp_t model(logic [N-1:0] el, logic [2:0] g, logic [8:0] rl, logic fx);
        exp_t  e;
        logic [7:0] pm;
        e.vld = 0; e.line = 0; e.prio = 0; e.pre = 0; e.due = 0; e.tag = "";
        for (int i = 0; i < N; i++) begin
            if (el[i] && (!e.vld || ((pr[i] & IMPL) < e.prio))) begin
                e.vld = 1; e.line = i; e.prio = pr[i] & IMPL;
            end
        end
        pm = (g == 3'd7) ? 8'h00 : 8'(8'hFF << (g + 1));
        e.pre = e.vld && !fx && (rl[8] || ((e.prio & pm) < (rl[7:0] & IMPL & pm)));
        return e;
    endfunction

    // driver: one input set per cycle, expected item queued
    task automatic apply(logic [N-1:0] el, logic [2:0] g, logic [8:0] rl, logic fx, string tag);
        exp_t e;
        @(negedge clk);
        eligible  = el;
        group_sel = g;
        run_level = rl;
        run_fixed = fx;
        for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = pr[i];
        e = model(el, g, rl, fx);
        e.due = cyc + LAT;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (win_vld !== e.vld || preempt_req !== e.pre ||
                (e.vld && (int'(win_line) != e.line || win_prio !== e.prio))) begin
                n_fail++;
                $display("FAIL %s: got vld=%0d line=%0d prio=%02h pre=%0d, expected vld=%0d line=%0d prio=%02h pre=%0d",
                         e.tag, win_vld, win_line, win_prio, preempt_req,
                         e.vld, e.line, e.prio, e.pre);
            end
        end
    end

    task automatic set_all(logic [7:0] v);
        for (int i = 0; i < N; i++) pr[i] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got no end, expected end of test");
        report();
    end

    initial begin
        set_all(8'h00);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        n_chk++;
        if (win_vld !== 0 || preempt_req !== 0 || win_prio !== 0) begin
            n_fail++;
            $display("FAIL R8 reset: got vld=%0d pre=%0d prio=%02h, expected 0 0 00",
                     win_vld, preempt_req, win_prio);
        end

        // R8 nothing eligible
        apply('0, 3'd0, 9'h100, 0, "R8");
        // R1 / R7 ordering, idle
        set_all(8'hE0); pr[5] = 8'h20; pr[2] = 8'h60;
        apply(8'b0010_0101, 3'd0, 9'h100, 0, "R1");
        // R2 unbuilt bits ignored: 0x1F masks to 0x00, beats 0x20
        set_all(8'hE0); pr[0] = 8'h20; pr[1] = 8'h1F;
        apply(8'b0000_0011, 3'd0, 9'h100, 0, "R2");
        // R2/R3 0x5F and 0x41 both mask to 0x40, lower line wins
        set_all(8'hE0); pr[3] = 8'h5F; pr[6] = 8'h41;
        apply(8'b0100_1000, 3'd0, 9'h100, 0, "R3");
        // R3 equal priorities scattered
        set_all(8'h80);
        apply(8'b1011_0000, 3'd2, 9'h0E0, 0, "R3");
        // R4 G=5: request 0x80, running 0xA0 -> same preempt field
        set_all(8'hE0); pr[4] = 8'h80;
        apply(8'b0001_0000, 3'd5, 9'h0A0, 0, "R4");
        // R4 G=4: same pair, now strictly smaller
        apply(8'b0001_0000, 3'd4, 9'h0A0, 0, "R4");
        // R4 G=5 request 0x40 vs running 0x80
        pr[4] = 8'h40;
        apply(8'b0001_0000, 3'd5, 9'h080, 0, "R4");
        // R4 equal full priority never preempts
        pr[4] = 8'h80;
        apply(8'b0001_0000, 3'd0, 9'h080, 0, "R4");
        // R10 running 0x9F with G=4 masks to 0x80
        apply(8'b0001_0000, 3'd4, 9'h09F, 0, "R10");
        // R5 G=7
        pr[4] = 8'h00;
        apply(8'b0001_0000, 3'd7, 9'h0E0, 0, "R5");
        // R6 fixed level running
        apply(8'b0001_0000, 3'd0, 9'h100, 1, "R6");
        apply(8'b0001_0000, 3'd0, 9'h0E0, 1, "R6");
        // R7 idle with lowest priority request
        pr[7] = 8'hFF;
        apply(8'b1000_0000, 3'd3, 9'h100, 0, "R7");
        // R9 back-to-back random stream
        for (int t = 0; t < 400; t++) begin
            for (int i = 0; i < N; i++) pr[i] = 8'($urandom);
            apply(N'($urandom), 3'($urandom), 9'($urandom), (($urandom % 8) == 0), "R9");
        end
        repeat (LAT + 3) @(negedge clk);
        n_chk++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R9: got %0d pending results, expected 0", sb.size());
        end
        report();
    end
endmodule